// File: doc/BRIEF.md
# Converter Register Access Sequencer

This block sits between a host-side register request port and an existing SPI shift engine that reports its state through a single idle flag. The host loads a converter select, a register address, write data and a direction (or a gain request), then pulses a start strobe. The sequencer then runs the whole access without further help. First it writes the converter's access-mode register to put the part in read or write mode. Then it performs the requested register transfer. Every engine transfer uses the same handshake: wait for idle, present the request, wait for idle to fall, then wait for it to rise again.

A gain helper turns a requested gain step (0 to 12, half-dB steps from 0 dB to 6 dB) into the upper nibble of the gain register at address 0x55. It does this as a read-modify-write, so the register's lower nibble survives. If the engine never takes a request within a host-programmed number of cycles, the access is aborted and an error flag is raised.

Control states: `C_IDLE`, `C_SET_RD_MODE`, `C_READ`, `C_SET_WR_MODE`, `C_WRITE`, `C_DONE`.
- `C_IDLE`→`C_SET_RD_MODE` on start with read or gain; `C_IDLE`→`C_SET_WR_MODE` on start with write.
- `C_SET_RD_MODE`→`C_READ` and `C_SET_WR_MODE`→`C_WRITE` on transfer finish.
- `C_READ`→`C_SET_WR_MODE` on finish of a gain access; `C_READ`→`C_DONE` on finish of a plain read.
- `C_WRITE`→`C_DONE` on finish.
- `C_DONE`→`C_IDLE` always.
- Any step state→`C_IDLE` on abort.

Transfer states: `X_IDLE`, `X_WAIT_READY`, `X_ISSUE`, `X_DRAIN`.
- `X_IDLE`→`X_WAIT_READY` on go.
- `X_WAIT_READY`→`X_ISSUE` when idle is high.
- `X_ISSUE`→`X_DRAIN` when idle falls; `X_ISSUE`→`X_IDLE` on timeout.
- `X_DRAIN`→`X_IDLE` when idle returns.

Top module: `regseq_top`

## Requirements
- R1: `eng_req` rises only in a cycle after `eng_idle` was sampled high. No request is presented while the engine is busy.
- R2: Once raised, `eng_req` and its address, data, select and direction stay steady until `eng_idle` falls. A transfer is only complete after `eng_idle` has returned high.
- R3: For a read, `rdata` is the value on `eng_rdata` sampled after `eng_idle` returns high.
- R4: A plain write first writes value 0x00 to address 0x00, then writes the target. A plain read first writes value 0x01 to address 0x00, then reads the target.
- R5: `busy` is high from the cycle after an accepted start through the `done` cycle. A start seen while busy is ignored and causes no engine transfer.
- R6: `done` is high for exactly one cycle per completed access. In that cycle `rdata` holds the read value (read) or the last value written (write, gain).
- R7: A gain access performs four transfers in this order: mode 0x01 to 0x00, read 0x55, mode 0x00 to 0x00, write 0x55. The written value carries the gain code in bits 7:4 and keeps bits 3:0 as read.
- R8: Gain codes 13 to 15 are clamped to 12 before they are written.
- R9: Every transfer of an access carries the converter select latched at start (0 = channels 0–1 converter, 1 = channels 2–3 converter). The other converter's registers are not touched.
- R10: If `eng_idle` stays high for `accept_limit` cycles while a request is presented, the access aborts. In that case `err` is set, `busy` drops and `done` is not pulsed. `err` clears on the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_start | input | 1 | Start strobe, accepted only when not busy |
| host_sel | input | 1 | Converter select (0: channels 0–1, 1: channels 2–3) |
| host_addr | input | AW | Target register address |
| host_wdata | input | DW | Write data for a plain write |
| host_rd | input | 1 | 1 = read, 0 = write |
| host_gain | input | 1 | 1 = gain access (overrides host_rd) |
| host_gain_code | input | GW | Requested gain step, 0..12 |
| accept_limit | input | CNT_W | Cycles allowed for the engine to take a request |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last access aborted on timeout |
| rdata | output | DW | Read value or last written value |
| eng_req | output | 1 | Request presented to the engine |
| eng_sel | output | 1 | Converter select to the engine |
| eng_addr | output | AW | Register address to the engine |
| eng_wdata | output | DW | Write data to the engine |
| eng_rd | output | 1 | Transfer direction to the engine |
| eng_idle | input | 1 | Engine idle flag |
| eng_rdata | input | DW | Engine read data |

## Verification
The bench builds the block with its default widths: 8-bit address and data, a 4-bit gain field and a 16-bit timeout counter. It drives `accept_limit` at 64 for normal accesses and at 5 for the abort case, so the timeout path is reached within a handful of cycles. The modelled engine keeps a mode byte per converter. It ignores register writes outside write mode and returns a marker value for reads outside read mode, so a missing or wrong mode prefix shows up as wrong data. A 0x55 preload with distinct lower nibbles on both converters exposes both merge errors and misrouted selects.

// File: rtl/seq_pkg.sv
package seq_pkg;

    typedef enum logic [1:0] {
        X_IDLE,
        X_WAIT_READY,
        X_ISSUE,
        X_DRAIN
    } xfer_state_t;

    typedef enum logic [2:0] {
        C_IDLE,
        C_SET_RD_MODE,
        C_READ,
        C_SET_WR_MODE,
        C_WRITE,
        C_DONE
    } ctl_state_t;

    typedef enum logic [1:0] {
        OP_WRITE,
        OP_READ,
        OP_GAIN
    } op_t;

endpackage

// File: rtl/seq_gain.sv
module seq_gain #(
    parameter int DW       = 8,
    parameter int GW       = 4,
    parameter int GAIN_MAX = 12
) (
    input  logic [GW-1:0] code,
    input  logic [DW-1:0] cur,
    output logic [DW-1:0] merged
);
    localparam int            SHIFT    = DW - GW;
    localparam logic [GW-1:0] GMAX     = GW'(GAIN_MAX);
    localparam logic [DW-1:0] LOW_MASK = {{GW{1'b0}}, {SHIFT{1'b1}}};

    logic [GW-1:0] clamped;

    always_comb begin
        clamped = (code > GMAX) ? GMAX : code;
        merged  = (cur & LOW_MASK) | ({{SHIFT{1'b0}}, clamped} << SHIFT);
    end

    // R8
    gain_clamp_chk: assert final (merged[DW-1:SHIFT] <= GMAX)
        else $error("gain field above limit");

endmodule

// File: rtl/seq_xfer.sv
module seq_xfer
    import seq_pkg::*;
#(
    parameter int AW    = 8,
    parameter int DW    = 8,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             go_sel,
    input  logic [AW-1:0]    go_addr,
    input  logic [DW-1:0]    go_wdata,
    input  logic             go_rd,
    input  logic [CNT_W-1:0] limit,
    input  logic             eng_idle,
    input  logic [DW-1:0]    eng_rdata,
    output logic             eng_req,
    output logic             eng_sel,
    output logic [AW-1:0]    eng_addr,
    output logic [DW-1:0]    eng_wdata,
    output logic             eng_rd,
    output logic             fin,
    output logic             abort,
    output logic [DW-1:0]    rd_data
);
    xfer_state_t       state, state_nx;
    logic [CNT_W-1:0]  wait_cnt;
    logic              hit;
    logic              sel_q, rd_q, fin_q, abort_q;
    logic [AW-1:0]     addr_q;
    logic [DW-1:0]     wdata_q, data_q;

    assign hit = ({1'b0, wait_cnt} + {{CNT_W{1'b0}}, 1'b1}) >= {1'b0, limit};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= X_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            X_IDLE:       if (go)       state_nx = X_WAIT_READY;
            X_WAIT_READY: if (eng_idle) state_nx = X_ISSUE;
            X_ISSUE: begin
                if (!eng_idle)  state_nx = X_DRAIN;
                else if (hit)   state_nx = X_IDLE;
            end
            X_DRAIN:      if (eng_idle) state_nx = X_IDLE;
            default:                    state_nx = X_IDLE;
        endcase
    end

    // outputs and data path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q    <= 1'b0;
            rd_q     <= 1'b0;
            addr_q   <= '0;
            wdata_q  <= '0;
            data_q   <= '0;
            wait_cnt <= '0;
            fin_q    <= 1'b0;
            abort_q  <= 1'b0;
        end else begin
            fin_q   <= 1'b0;
            abort_q <= 1'b0;
            if (state == X_IDLE && go) begin
                sel_q   <= go_sel;
                rd_q    <= go_rd;
                addr_q  <= go_addr;
                wdata_q <= go_wdata;
            end
            if (state == X_WAIT_READY)
                wait_cnt <= '0;
            else if (state == X_ISSUE)
                wait_cnt <= wait_cnt + 1'b1;
            if (state == X_ISSUE && eng_idle && hit)
                abort_q <= 1'b1;
            if (state == X_DRAIN && eng_idle) begin
                fin_q <= 1'b1;
                if (rd_q) data_q <= eng_rdata;
            end
        end
    end

    assign eng_req   = (state == X_ISSUE);
    assign eng_sel   = sel_q;
    assign eng_addr  = addr_q;
    assign eng_wdata = wdata_q;
    assign eng_rd    = rd_q;
    assign fin       = fin_q;
    assign abort     = abort_q;
    assign rd_data   = data_q;

    // R1
    req_after_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eng_req) |-> $past(eng_idle))
        else $error("request raised without idle");

    // R2
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && eng_idle) |=> (eng_req || abort))
        else $error("request dropped before engine took it");

    // R2
    req_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_req && $past(eng_req)) |-> ($stable(eng_addr) && $stable(eng_wdata) && $stable(eng_sel)))
        else $error("request fields moved while presented");

    // R3
    fin_after_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fin |-> ($past(eng_idle) && $past(state == X_DRAIN)))
        else $error("transfer finished before idle returned");

    // R10
    abort_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> $past(eng_req && eng_idle))
        else $error("abort without stalled request");

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
    import seq_pkg::*;
#(
    parameter int AW          = 8,
    parameter int DW          = 8,
    parameter int GW          = 4,
    parameter int MODE_ADDR   = 0,
    parameter int GAIN_ADDR   = 'h55,
    parameter int GAIN_MAX    = 12,
    parameter int MODE_RD_VAL = 1,
    parameter int MODE_WR_VAL = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          sel,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          rd,
    input  logic          gain,
    input  logic [GW-1:0] gain_code,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic [DW-1:0] rdata,
    output logic          go,
    output logic          x_sel,
    output logic [AW-1:0] x_addr,
    output logic [DW-1:0] x_wdata,
    output logic          x_rd,
    input  logic          fin,
    input  logic          abort,
    input  logic [DW-1:0] x_rdata
);
    localparam logic [AW-1:0] MODE_A = AW'(MODE_ADDR);
    localparam logic [AW-1:0] GAIN_A = AW'(GAIN_ADDR);
    localparam logic [DW-1:0] M_RD   = DW'(MODE_RD_VAL);
    localparam logic [DW-1:0] M_WR   = DW'(MODE_WR_VAL);

    ctl_state_t    state, state_nx;
    op_t           op_q;
    logic          sel_q, armed, err_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wr_val, rdata_q, merged;
    logic [GW-1:0] code_q;
    logic          step;

    seq_gain #(.DW(DW), .GW(GW), .GAIN_MAX(GAIN_MAX)) u_gain (
        .code   (code_q),
        .cur    (x_rdata),
        .merged (merged)
    );

    assign step = (state == C_SET_RD_MODE) || (state == C_READ) ||
                  (state == C_SET_WR_MODE) || (state == C_WRITE);
    assign go   = step && !armed;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= C_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            C_IDLE:
                if (start) state_nx = (gain || rd) ? C_SET_RD_MODE : C_SET_WR_MODE;
            C_SET_RD_MODE:
                if (abort)    state_nx = C_IDLE;
                else if (fin) state_nx = C_READ;
            C_READ:
                if (abort)    state_nx = C_IDLE;
                else if (fin) state_nx = (op_q == OP_GAIN) ? C_SET_WR_MODE : C_DONE;
            C_SET_WR_MODE:
                if (abort)    state_nx = C_IDLE;
                else if (fin) state_nx = C_WRITE;
            C_WRITE:
                if (abort)    state_nx = C_IDLE;
                else if (fin) state_nx = C_DONE;
            C_DONE:           state_nx = C_IDLE;
            default:          state_nx = C_IDLE;
        endcase
    end

    // registered outputs and operands
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q    <= OP_WRITE;
            sel_q   <= 1'b0;
            addr_q  <= '0;
            code_q  <= '0;
            wr_val  <= '0;
            rdata_q <= '0;
            armed   <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            if (state == C_IDLE && start) begin
                op_q   <= gain ? OP_GAIN : (rd ? OP_READ : OP_WRITE);
                sel_q  <= sel;
                addr_q <= addr;
                code_q <= gain_code;
                wr_val <= wdata;
                err_q  <= 1'b0;
            end
            if (go)               armed <= 1'b1;
            else if (fin || abort) armed <= 1'b0;
            if (abort) err_q <= 1'b1;
            if (fin && state == C_READ) begin
                if (op_q == OP_GAIN) wr_val  <= merged;
                else                 rdata_q <= x_rdata;
            end
            if (fin && state == C_WRITE) rdata_q <= wr_val;
        end
    end

    // transfer operands per step
    always_comb begin
        x_sel   = sel_q;
        x_addr  = (op_q == OP_GAIN) ? GAIN_A : addr_q;
        x_wdata = wr_val;
        x_rd    = 1'b0;
        unique case (state)
            C_SET_RD_MODE: begin x_addr = MODE_A; x_wdata = M_RD; end
            C_SET_WR_MODE: begin x_addr = MODE_A; x_wdata = M_WR; end
            C_READ:        x_rd = 1'b1;
            default:       ;
        endcase
    end

    assign busy  = (state != C_IDLE);
    assign done  = (state == C_DONE);
    assign err   = err_q;
    assign rdata = rdata_q;

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done)
        else $error("done wider than one cycle");

    // R5
    done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy)
        else $error("done outside busy");

    // R4
    read_after_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == C_READ && $past(state) != C_READ) |-> $past(state) == C_SET_RD_MODE)
        else $error("read without read-mode prefix");

    // R4
    write_after_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == C_WRITE && $past(state) != C_WRITE) |-> $past(state) == C_SET_WR_MODE)
        else $error("write without write-mode prefix");

    // R10
    abort_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (err && !busy))
        else $error("abort did not raise error");

endmodule

// File: rtl/regseq_top.sv
module regseq_top
    import seq_pkg::*;
#(
    parameter int AW          = 8,
    parameter int DW          = 8,
    parameter int GW          = 4,
    parameter int CNT_W       = 16,
    parameter int MODE_ADDR   = 0,
    parameter int GAIN_ADDR   = 'h55,
    parameter int GAIN_MAX    = 12,
    parameter int MODE_RD_VAL = 1,
    parameter int MODE_WR_VAL = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_start,
    input  logic             host_sel,
    input  logic [AW-1:0]    host_addr,
    input  logic [DW-1:0]    host_wdata,
    input  logic             host_rd,
    input  logic             host_gain,
    input  logic [GW-1:0]    host_gain_code,
    input  logic [CNT_W-1:0] accept_limit,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic [DW-1:0]    rdata,
    output logic             eng_req,
    output logic             eng_sel,
    output logic [AW-1:0]    eng_addr,
    output logic [DW-1:0]    eng_wdata,
    output logic             eng_rd,
    input  logic             eng_idle,
    input  logic [DW-1:0]    eng_rdata
);
    logic          go, x_sel, x_rd, fin, abort;
    logic [AW-1:0] x_addr;
    logic [DW-1:0] x_wdata, x_rdata;

    seq_ctrl #(
        .AW(AW), .DW(DW), .GW(GW),
        .MODE_ADDR(MODE_ADDR), .GAIN_ADDR(GAIN_ADDR), .GAIN_MAX(GAIN_MAX),
        .MODE_RD_VAL(MODE_RD_VAL), .MODE_WR_VAL(MODE_WR_VAL)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (host_start),
        .sel       (host_sel),
        .addr      (host_addr),
        .wdata     (host_wdata),
        .rd        (host_rd),
        .gain      (host_gain),
        .gain_code (host_gain_code),
        .busy      (busy),
        .done      (done),
        .err       (err),
        .rdata     (rdata),
        .go        (go),
        .x_sel     (x_sel),
        .x_addr    (x_addr),
        .x_wdata   (x_wdata),
        .x_rd      (x_rd),
        .fin       (fin),
        .abort     (abort),
        .x_rdata   (x_rdata)
    );

    seq_xfer #(.AW(AW), .DW(DW), .CNT_W(CNT_W)) u_xfer (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .go_sel    (x_sel),
        .go_addr   (x_addr),
        .go_wdata  (x_wdata),
        .go_rd     (x_rd),
        .limit     (accept_limit),
        .eng_idle  (eng_idle),
        .eng_rdata (eng_rdata),
        .eng_req   (eng_req),
        .eng_sel   (eng_sel),
        .eng_addr  (eng_addr),
        .eng_wdata (eng_wdata),
        .eng_rd    (eng_rd),
        .fin       (fin),
        .abort     (abort),
        .rd_data   (x_rdata)
    );

    // R9
    sel_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && eng_req) |-> $stable(eng_sel))
        else $error("converter select changed mid-access");

endmodule

// File: tb/sim_regseq_top.sv
`timescale 1ns/1ps
module sim_regseq_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        h_start = 0, h_sel = 0, h_rd = 0, h_gain = 0;
    logic [7:0]  h_addr = 0, h_wdata = 0;
    logic [3:0]  h_code = 0;
    logic [15:0] limit = 16'd64;
    logic        busy, done, err, eng_req, eng_sel, eng_rd;
    logic [7:0]  rdata, eng_addr, eng_wdata;
    logic        eng_idle;
    logic [7:0]  eng_rdata;

    always #2.5 clk = ~clk;

    regseq_top u0 (
        .clk(clk), .rst_n(rst_n), .host_start(h_start), .host_sel(h_sel),
        .host_addr(h_addr), .host_wdata(h_wdata), .host_rd(h_rd),
        .host_gain(h_gain), .host_gain_code(h_code), .accept_limit(limit),
        .busy(busy), .done(done), .err(err), .rdata(rdata),
        .eng_req(eng_req), .eng_sel(eng_sel), .eng_addr(eng_addr),
        .eng_wdata(eng_wdata), .eng_rd(eng_rd), .eng_idle(eng_idle),
        .eng_rdata(eng_rdata)
    );

    // ---------------- engine and converter model ----------------
    logic [7:0] mreg [0:1][0:255];
    logic [7:0] mode [0:1];
    logic       log_sel [0:31];
    logic [7:0] log_addr [0:31];
    logic [7:0] log_data [0:31];
    logic       log_rd [0:31];
    int         log_n = 0;
    logic       stuck = 0;
    logic       idle_m;
    int         phase, cnt;
    logic       t_sel, t_rd;
    logic [7:0] t_addr, t_data;

    assign eng_idle = idle_m;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_m <= 1'b1; phase <= 0; cnt <= 0; eng_rdata <= 8'h00;
            mode[0] <= 8'hFF; mode[1] <= 8'hFF;
        end else begin
            case (phase)
                0: if (eng_req && idle_m && !stuck) begin cnt <= 2; phase <= 1; end
                1: if (cnt == 0) begin
                       idle_m <= 1'b0; t_sel <= eng_sel; t_rd <= eng_rd;
                       t_addr <= eng_addr; t_data <= eng_wdata;
                       cnt <= 3; phase <= 2;
                   end else cnt <= cnt - 1;
                default: if (cnt == 0) begin
                       if (t_rd)
                           eng_rdata <= (mode[t_sel] == 8'h01) ? mreg[t_sel][t_addr] : 8'hEE;
                       else if (t_addr == 8'h00)
                           mode[t_sel] <= t_data;
                       else if (mode[t_sel] == 8'h00)
                           mreg[t_sel][t_addr] <= t_data;
                       if (log_n < 32) begin
                           log_sel[log_n] <= t_sel; log_addr[log_n] <= t_addr;
                           log_data[log_n] <= t_data; log_rd[log_n] <= t_rd;
                       end
                       log_n <= log_n + 1;
                       idle_m <= 1'b1; phase <= 0;
                   end else cnt <= cnt - 1;
            endcase
        end
    end

    // ---------------- protocol monitors (sampled at negedge) ----------------
    int   proto_bad = 0, done_bad = 0;
    logic p_req = 0, p_idle = 1, p_done = 0;
    logic [7:0] p_addr = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (eng_req && !p_req && !p_idle) proto_bad++;              // R1
            if (!eng_req && p_req && p_idle && !stuck) proto_bad++;     // R2
            if (eng_req && p_req && eng_addr != p_addr) proto_bad++;    // R2
            if (done && p_done) done_bad++;                             // R6
        end
        p_req = eng_req; p_idle = eng_idle; p_done = done; p_addr = eng_addr;
    end

    // ---------------- scoring ----------------
    int checks = 0, fails = 0;
    bit finished = 0;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic run_op(input logic sel, input logic [7:0] a, input logic [7:0] d,
                          input logic rd, input logic g, input logic [3:0] code,
                          output bit got_done, output logic [7:0] got_data);
        @(negedge clk);
        h_sel = sel; h_addr = a; h_wdata = d; h_rd = rd; h_gain = g; h_code = code;
        h_start = 1;
        @(negedge clk);
        h_start = 0;
        got_done = 0; got_data = 8'h00;
        for (int i = 0; i < 3000; i++) begin
            if (done) begin got_done = 1; got_data = rdata; end
            if (!busy) break;
            @(negedge clk);
        end
    endtask

    task automatic check_log(input string req, input int idx, input logic s,
                             input logic [7:0] a, input logic [7:0] d, input logic r);
        check(req, log_sel[idx], s);
        check(req, log_addr[idx], a);
        if (!r) check(req, log_data[idx], d);
        check(req, log_rd[idx], r);
    endtask

    task automatic t_reset;
        check("R5 reset busy", busy, 0);
        check("R6 reset done", done, 0);
        check("R10 reset err", err, 0);
        check("R1 reset req", eng_req, 0);
    endtask

    task automatic t_write;
        bit dn; logic [7:0] v; int b;
        b = log_n;
        run_op(1'b1, 8'h21, 8'hA5, 1'b0, 1'b0, 4'd0, dn, v);
        check("R6 write done", dn, 1);
        check("R6 write rdata", v, 8'hA5);
        check("R4 write count", log_n - b, 2);
        check_log("R4 write mode prefix", b, 1'b1, 8'h00, 8'h00, 1'b0);
        check_log("R9 write target", b + 1, 1'b1, 8'h21, 8'hA5, 1'b0);
        check("R9 write stored", mreg[1][8'h21], 8'hA5);
        check("R9 other converter", mreg[0][8'h21], 8'h00);
    endtask

    task automatic t_read;
        bit dn; logic [7:0] v; int b;
        b = log_n;
        run_op(1'b0, 8'h40, 8'h00, 1'b1, 1'b0, 4'd0, dn, v);
        check("R6 read done", dn, 1);
        check("R3 read data", v, 8'h3C);
        check("R4 read count", log_n - b, 2);
        check_log("R4 read mode prefix", b, 1'b0, 8'h00, 8'h01, 1'b0);
        check_log("R4 read target", b + 1, 1'b0, 8'h40, 8'h00, 1'b1);
    endtask

    task automatic t_gain(input logic sel, input logic [3:0] code, input logic [7:0] exp,
                          input string req);
        bit dn; logic [7:0] v; int b;
        b = log_n;
        run_op(sel, 8'h00, 8'h00, 1'b0, 1'b1, code, dn, v);
        check({req, " gain done"}, dn, 1);
        check({req, " gain count"}, log_n - b, 4);
        check_log("R7 gain step1", b, sel, 8'h00, 8'h01, 1'b0);
        check_log("R7 gain step2", b + 1, sel, 8'h55, 8'h00, 1'b1);
        check_log("R7 gain step3", b + 2, sel, 8'h00, 8'h00, 1'b0);
        check_log({req, " gain step4"}, b + 3, sel, 8'h55, exp, 1'b0);
        check({req, " gain stored"}, mreg[sel][8'h55], exp);
        check({req, " gain rdata"}, v, exp);
    endtask

    task automatic t_busy_ignore;
        int b;
        b = log_n;
        @(negedge clk);
        h_sel = 0; h_addr = 8'h10; h_wdata = 8'h11; h_rd = 0; h_gain = 0; h_start = 1;
        @(negedge clk);
        h_start = 0;
        check("R5 busy after start", busy, 1);
        repeat (3) @(negedge clk);
        h_addr = 8'h33; h_wdata = 8'h99; h_start = 1;
        @(negedge clk);
        h_start = 0;
        for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
        repeat (40) @(negedge clk);
        check("R5 ignored start count", log_n - b, 2);
        check("R5 ignored start target", mreg[0][8'h33], 8'h00);
        check("R5 first op stored", mreg[0][8'h10], 8'h11);
        check("R5 idle after", busy, 0);
    endtask

    task automatic t_timeout;
        bit dn; logic [7:0] v; int b;
        stuck = 1; limit = 16'd5;
        b = log_n;
        run_op(1'b0, 8'h12, 8'h34, 1'b0, 1'b0, 4'd0, dn, v);
        check("R10 no done", dn, 0);
        check("R10 err set", err, 1);
        check("R10 busy dropped", busy, 0);
        check("R10 no transfer", log_n - b, 0);
        stuck = 0; limit = 16'd64;
        @(negedge clk);
        h_start = 1; h_sel = 0; h_addr = 8'h12; h_wdata = 8'h34; h_rd = 0; h_gain = 0;
        @(negedge clk);
        h_start = 0;
        check("R10 err cleared", err, 0);
        for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
        check("R10 retry stored", mreg[0][8'h12], 8'h34);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        for (int s = 0; s < 2; s++)
            for (int a = 0; a < 256; a++) mreg[s][a] = 8'h00;
        mreg[0][8'h40] = 8'h3C;
        mreg[0][8'h55] = 8'h0B;
        mreg[1][8'h55] = 8'h96;
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset;
        t_write;
        t_read;
        t_gain(1'b0, 4'd5, 8'h5B, "R7");
        check("R9 other gain untouched", mreg[1][8'h55], 8'h96);
        t_gain(1'b1, 4'd14, 8'hC6, "R8");
        t_gain(1'b0, 4'd12, 8'hCB, "R8 max");
        t_busy_ignore;
        t_timeout;
        check("R1 R2 protocol monitor", proto_bad, 0);
        check("R6 done width monitor", done_bad, 0);
        finish_run;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run;
    end

endmodule